// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a behavioural, synthesizable model of a synchronous burst static RAM. Every control and data input is sampled on the rising clock edge. Byte lanes are 8 bits wide. An access begins when one of two active-low start strobes is asserted, one for a processor-side requester and one for a controller-side requester. The start strobe loads the external address. After that, a 2-bit burst counter steps through the two lowest address bits while the active-low step input is held low. The counter steps in linear order or interleaved order. A level on a mode pin chooses the order.

Writes cover either every lane or only the lanes that are individually selected. Read data leaves through one of two paths:
- a flow-through path, where data appears right after the address is registered;
- a pipeline path, where data appears one clock later from an output register.

A bidirectional data pin is modelled as an input bus plus an output bus with an output-enable.

Parameters set the address width, which fixes the depth, and the number of byte lanes.

Top module: `sbs_sram`

## Requirements
- R1: With `lin_order_n` low, a burst loaded at address S visits addresses whose upper bits equal those of S and whose two low bits are (S[1:0]+n) mod 4 for n = 0,1,2,3, stepping once per cycle with `step_n` low.
- R2: With `lin_order_n` high, the n-th burst address has low bits S[1:0] XOR n, with the upper bits unchanged. For example, a start of 01 gives 01, 00, 11, 10.
- R3: A fifth step after the fourth burst address returns to the start address. A cycle with no strobe and `step_n` high repeats the access at the current burst address.
- R4: `start_cpu_n` low while the chip is selected loads the address and performs a read in that cycle whatever the write inputs say. It takes priority over `start_ctl_n` in the same cycle.
- R5: `start_cpu_n` low while the chip is not selected is ignored. A deselected chip stays deselected, and a running burst continues as if no strobe were present.
- R6: The chip is selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. `start_ctl_n` low loads the address when the chip is selected and ends any burst when it is not.
- R7: Lane i is data bits [8i+7:8i]. In an access cycle other than a processor start:
  - `gwe_n` low writes every lane;
  - otherwise, `bwe_n` low writes lane i where `lane_n[i]` is low;
  - in all other cases the cycle is a read.
- R8: With `pipe_mode` low (flow-through), the data of a read registered at edge k is on `d_out` with `d_oe` high after edge k.
- R9: With `pipe_mode` high, read data registered at edge k appears after edge k+1. After a deselect edge, `d_oe` falls one clock later.
- R10: `d_oe` is low at once while `oe_n` is high. It is also low while the write inputs request a write (`gwe_n` low, or `bwe_n` low with any `lane_n` bit low).
- R11: While `sleep` is high, no write, load or counter step occurs, and stored data is kept. Read valid clears at that edge.
- R12: While and after reset, until a read is registered, `d_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | AW | External word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor-side start strobe, active low, higher priority |
| start_ctl_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst counter advance, active low |
| gwe_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane-selective write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep, active high |
| lin_order_n | input | 1 | Low: linear burst order; high: interleaved |
| pipe_mode | input | 1 | Low: flow-through reads; high: pipelined reads |
| d_in | input | 8*LANES | Write data |
| d_out | output | 8*LANES | Read data |
| d_oe | output | 1 | Drive enable for `d_out` |

## Verification
The bench goes after the following corner cases:
- The counter wrap on the fifth step and the held address when `step_n` is high. A counter that saturates or free-runs would read the wrong word.
- Both strobes asserted together with a write request. A design that let the controller strobe win would overwrite the word it should only read.
- A processor strobe while deselected. A design that honoured it would start driving the bus.
- Partial lane writes to the same word, which catch swapped or merged lane masks.
- The one-clock lag of the pipeline path after a deselect. A design whose output register followed the deselect at once, or lagged two clocks, would show the wrong `d_oe`.
- Sleep with a write and a step requested, which catches designs that corrupt data or move the counter while asleep.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PLOAD,
        OP_CLOAD,
        OP_STEP,
        OP_HOLD,
        OP_DESEL
    } op_e;

    // Low two address bits of burst beat `step` from `start`.
    function automatic logic [1:0] burst_lsb(
        input logic [1:0] start,
        input logic [1:0] step,
        input logic       linear
    );
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
    import sbs_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             sel_en,
    input  logic             start_cpu_n,
    input  logic             start_ctl_n,
    input  logic             step_n,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             sleep,
    input  logic             linear,
    output logic [LANES-1:0] we_mask,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    addr_q,
    output logic             rd_q
);

    typedef struct packed {
        logic          act;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        logic          rd;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t            s_q, s_d;
    op_e             op;
    logic [LANES-1:0] req_mask;
    logic            access;

    always_comb begin
        s_d      = s_q;
        op       = OP_IDLE;
        we_mask  = '0;
        req_mask = !gwe_n ? '1 : (!bwe_n ? ~lane_n : '0);

        if (sleep)                        op = OP_IDLE;
        else if (!start_cpu_n && sel_en)  op = OP_PLOAD;
        else if (!start_ctl_n)            op = sel_en ? OP_CLOAD : OP_DESEL;
        else if (s_q.act)                 op = step_n ? OP_HOLD : OP_STEP;

        case (op)
            OP_PLOAD, OP_CLOAD: begin
                s_d.act  = 1'b1;
                s_d.base = addr;
                s_d.cnt  = 2'd0;
            end
            OP_STEP:  s_d.cnt = s_q.cnt + 2'd1;
            OP_DESEL: s_d.act = 1'b0;
            default:  ;
        endcase

        acc_addr = {s_d.base[AW-1:2], burst_lsb(s_d.base[1:0], s_d.cnt, linear)};
        access   = (op == OP_PLOAD) || (op == OP_CLOAD) ||
                   (op == OP_STEP)  || (op == OP_HOLD);

        if (access) begin
            we_mask  = (op == OP_PLOAD) ? '0 : req_mask;
            s_d.addr = acc_addr;
            s_d.rd   = ~|we_mask;
        end else begin
            s_d.rd   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_q = s_q.addr;
    assign rd_q   = s_q.rd;

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic [LANES-1:0]     we_mask,
    input  logic [AW-1:0]        waddr,
    input  logic [8*LANES-1:0]   wdata,
    input  logic [AW-1:0]        raddr,
    output logic [8*LANES-1:0]   rdata
);

    localparam int DW    = 8 * LANES;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we_mask[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sbs_outpath.sv
module sbs_outpath #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          wreq,
    input  logic          rd_q,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] d_out,
    output logic          d_oe
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } out_t;

    out_t o_q, o_d;
    logic vld_sel;

    always_comb begin
        o_d.vld = rd_q;
        o_d.dat = rdata;
        vld_sel = pipe_mode ? o_q.vld : rd_q;
        d_out   = pipe_mode ? o_q.dat : rdata;
        d_oe    = vld_sel && !oe_n && !wreq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 sel_a_n,
    input  logic                 sel_b,
    input  logic                 sel_c_n,
    input  logic                 start_cpu_n,
    input  logic                 start_ctl_n,
    input  logic                 step_n,
    input  logic                 gwe_n,
    input  logic                 bwe_n,
    input  logic [LANES-1:0]     lane_n,
    input  logic                 oe_n,
    input  logic                 sleep,
    input  logic                 lin_order_n,
    input  logic                 pipe_mode,
    input  logic [8*LANES-1:0]   d_in,
    output logic [8*LANES-1:0]   d_out,
    output logic                 d_oe
);

    localparam int DW = 8 * LANES;

    logic             sel_en;
    logic             wreq;
    logic [LANES-1:0] we_mask;
    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    addr_q;
    logic             rd_q;
    logic [DW-1:0]    rdata;

    assign sel_en = !sel_a_n && sel_b && !sel_c_n;
    assign wreq   = !gwe_n || (!bwe_n && !(&lane_n));

    sbs_burst_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .sel_en      (sel_en),
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .step_n      (step_n),
        .gwe_n       (gwe_n),
        .bwe_n       (bwe_n),
        .lane_n      (lane_n),
        .sleep       (sleep),
        .linear      (!lin_order_n),
        .we_mask     (we_mask),
        .acc_addr    (acc_addr),
        .addr_q      (addr_q),
        .rd_q        (rd_q)
    );

    sbs_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk     (clk),
        .we_mask (we_mask),
        .waddr   (acc_addr),
        .wdata   (d_in),
        .raddr   (addr_q),
        .rdata   (rdata)
    );

    sbs_outpath #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .wreq      (wreq),
        .rd_q      (rd_q),
        .rdata     (rdata),
        .d_out     (d_out),
        .d_oe      (d_oe)
    );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             start_cpu_n,
    input logic             start_ctl_n,
    input logic             step_n,
    input logic             sel_en,
    input logic             pipe_mode,
    input logic             oe_n,
    input logic             wreq,
    input logic [LANES-1:0] we_mask,
    input logic [AW-1:0]    acc_addr,
    input logic [AW-1:0]    addr_q,
    input logic             rd_q,
    input logic             d_oe
);

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || wreq) |-> !d_oe);

    assert_pipe_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && !oe_n && !wreq) |-> (d_oe == $past(rd_q)));

    assert_sleep_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (we_mask == '0));

    assert_cpu_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !start_cpu_n && sel_en) |-> (we_mask == '0));

    assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start_cpu_n && start_ctl_n && step_n && rd_q) |-> (acc_addr == addr_q));

endmodule

bind sbs_sram sbs_checker #(.AW(AW), .LANES(LANES)) u_sbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .step_n      (step_n),
    .sel_en      (sel_en),
    .pipe_mode   (pipe_mode),
    .oe_n        (oe_n),
    .wreq        (wreq),
    .we_mask     (we_mask),
    .acc_addr    (acc_addr),
    .addr_q      (addr_q),
    .rd_q        (rd_q),
    .d_oe        (d_oe)
);

// File: tb/test_sbs_sram.sv
`timescale 1ns/1ps
module test_sbs_sram;
    localparam int AW = 8, LANES = 2, DW = 16, DEPTH = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sel_a_n = 0, sel_b = 1, sel_c_n = 0;
    logic start_cpu_n = 1, start_ctl_n = 1, step_n = 1;
    logic gwe_n = 1, bwe_n = 1;
    logic [LANES-1:0] lane_n = '1;
    logic oe_n = 0, sleep = 0, lin_order_n = 0, pipe_mode = 0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic d_oe;

    sbs_sram #(.AW(AW), .LANES(LANES)) i_sbs_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
        .step_n(step_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n),
        .sleep(sleep), .lin_order_n(lin_order_n), .pipe_mode(pipe_mode),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    always #2.5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    string tag = "R12";

    int mm [DEPTH];
    int kn [DEPTH];
    int m_act = 0, m_base = 0, m_cnt = 0, m_rd = 0, m_addr = 0;
    int m_pv = 0, m_pd = 0, m_pk = 0;

    function automatic int pat(int a);
        return ((a * 37 + 11) ^ (a << 8)) & 16'hffff;
    endfunction

    task automatic chk(bit ok, string r, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic model_edge();
        int en, acc, wm, req, lsb, a;
        m_pv = m_rd;
        m_pd = mm[m_addr];
        m_pk = (kn[m_addr] == 3);
        en   = (!sel_a_n && sel_b && !sel_c_n);
        req  = !gwe_n ? 3 : (!bwe_n ? (~int'(lane_n) & 3) : 0);
        acc  = 0;
        wm   = 0;
        if (!sleep) begin
            if (!start_cpu_n && en) begin
                m_base = addr; m_cnt = 0; m_act = 1; acc = 1; wm = 0;
            end else if (!start_ctl_n) begin
                if (en) begin m_base = addr; m_cnt = 0; m_act = 1; acc = 1; wm = req; end
                else m_act = 0;
            end else if (m_act != 0) begin
                if (!step_n) m_cnt = (m_cnt + 1) % 4;
                acc = 1; wm = req;
            end
        end
        if (acc != 0) begin
            lsb = lin_order_n ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4);
            a   = (m_base & ~3) | lsb;
            for (int l = 0; l < LANES; l++) begin
                if (wm[l]) begin
                    mm[a] = (mm[a] & ~(255 << (8*l))) | (int'(d_in) & (255 << (8*l)));
                    kn[a] = kn[a] | (1 << l);
                end
            end
            m_addr = a;
            m_rd   = (wm == 0);
        end else begin
            m_rd = 0;
        end
    endtask

    task automatic tick();
        int wq, vld, eo, ed, ek;
        @(posedge clk);
        if (rst_n) model_edge();
        else begin m_act = 0; m_rd = 0; m_pv = 0; m_cnt = 0; m_addr = 0; end
        @(negedge clk);
        wq  = (!gwe_n || (!bwe_n && lane_n != 2'b11));
        vld = pipe_mode ? m_pv : m_rd;
        eo  = (vld != 0 && !oe_n && wq == 0);
        ed  = pipe_mode ? m_pd : mm[m_addr];
        ek  = pipe_mode ? m_pk : (kn[m_addr] == 3);
        chk(d_oe == eo[0], {tag, " d_oe"}, d_oe, eo);
        if (eo != 0 && ek != 0) chk(d_out == ed[DW-1:0], {tag, " d_out"}, d_out, ed);
    endtask

    task automatic idle();
        start_cpu_n = 1; start_ctl_n = 1; step_n = 1; gwe_n = 1; bwe_n = 1;
        lane_n = '1; sleep = 0; oe_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    task automatic deselect();
        idle(); start_ctl_n = 0; sel_b = 0; tick(); idle();
    endtask

    task automatic burst(int a, int beats, bit cpu);
        idle(); addr = a[AW-1:0];
        if (cpu) start_cpu_n = 0; else start_ctl_n = 0;
        tick(); idle(); step_n = 0;
        for (int i = 0; i < beats; i++) tick();
        idle();
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mm[i] = 0; kn[i] = 0; end
        @(negedge clk);
        tag = "R12"; tick(); tick();
        chk(d_oe == 1'b0, "R12 reset d_oe", d_oe, 0);
        rst_n = 1; tick();

        tag = "R7";
        for (int a = 0; a < 32; a++) begin
            idle(); start_ctl_n = 0; gwe_n = 0; addr = a[AW-1:0]; d_in = pat(a)[DW-1:0]; tick();
        end
        deselect();

        tag = "R8"; pipe_mode = 0; lin_order_n = 0;
        idle(); addr = 8'd5; start_ctl_n = 0; tick();
        tag = "R1"; idle(); step_n = 0; tick(); tick(); tick();
        tag = "R3"; tick(); idle(); tick(); tick();
        deselect();

        tag = "R2"; pipe_mode = 1; lin_order_n = 1;
        burst(14, 5, 1); tick();
        tag = "R6"; deselect();
        tag = "R9"; tick(); tick();

        tag = "R2"; pipe_mode = 0; burst(9, 4, 0); deselect();
        tag = "R1"; pipe_mode = 1; lin_order_n = 0; burst(18, 5, 0); tick(); deselect(); tick();

        tag = "R4"; idle(); addr = 8'd9; start_cpu_n = 0; start_ctl_n = 0; gwe_n = 0; d_in = 16'hdead; tick();
        idle(); tick(); tick(); deselect(); tick();

        tag = "R5"; idle(); start_cpu_n = 0; sel_a_n = 1; addr = 8'd20; tick();
        idle(); tick(); tick();
        pipe_mode = 0; idle(); addr = 8'd20; start_ctl_n = 0; tick();
        idle(); start_cpu_n = 0; sel_c_n = 1; addr = 8'd2; step_n = 0; tick(); tick();
        idle(); tick(); deselect();

        tag = "R7"; idle(); start_ctl_n = 0; addr = 8'd3; bwe_n = 0; lane_n = 2'b10; d_in = 16'ha5a5; tick();
        idle(); start_ctl_n = 0; addr = 8'd4; bwe_n = 0; lane_n = 2'b01; d_in = 16'h5a3c; tick();
        idle(); start_ctl_n = 0; addr = 8'd3; bwe_n = 0; lane_n = 2'b11; d_in = 16'h0; tick();
        idle(); start_ctl_n = 0; addr = 8'd4; tick();
        idle(); tick(); deselect();

        tag = "R10"; idle(); addr = 8'd8; start_ctl_n = 0; tick();
        idle(); oe_n = 1; tick(); idle(); tick(); oe_n = 1; tick(); idle(); tick(); deselect();

        tag = "R11"; pipe_mode = 1; idle(); addr = 8'd12; start_ctl_n = 0; tick();
        idle(); sleep = 1; gwe_n = 0; step_n = 0; d_in = 16'h0; tick(); tick();
        idle(); tick(); tick(); step_n = 0; tick(); tick();
        idle(); deselect(); tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule